// File: doc/BRIEF.md
# Second-Chance Clock Victim Selector

This block picks which physical frame to give up when a page fault needs room, using the clock form of second-chance replacement. The frames form a ring, and a hand register points at the frame that has been resident longest. For each frame the block keeps two bits: a "used" bit, which means the frame was touched recently, and a "dirty" bit, which means it was written since it was loaded.

The surrounding logic reports accesses to the block, one frame per cycle. A read sets the used bit, and a write sets both bits. A periodic tick ages every frame by clearing all the used bits. When a fault request arrives, the block moves the hand around the ring, looking at one frame per cycle. A frame that was used recently loses its used bit and is skipped. The first frame found with its used bit clear becomes the victim.

The block then reports the victim index, says whether that frame must be written back first, and pulses done. It treats the chosen frame as freshly loaded, so the frame's used bit is set and its dirty bit is cleared. Fetching the new page and carrying out the write-back are left to other logic.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset, busy and done are low, the hand points at frame 0, and every used and dirty bit is clear. A fault as the first action therefore returns victim 0 with victim_dirty low.
- R2: A fault is accepted only when fault_req is high at a clock edge while busy is low. busy then goes high from the next cycle. While busy is high, fault_req has no effect.
- R3: While busy, the block examines the frame under the hand once per clock edge. If that frame's used bit is clear, the following cycle shows done high for exactly one cycle, busy low, and victim equal to that frame's index.
- R4: While busy, a frame under the hand whose used bit is set has that bit cleared, and the hand moves to the next frame. After frame FRAMES-1 the hand moves to frame 0.
- R5: If every frame has its used bit set and no event arrives during the search, the sweep clears all the used bits. The victim is then the frame where the search started, and done appears FRAMES+1 edges after busy rose.
- R6: After a victim is chosen, the hand points one position past it, with wrap. The victim frame restarts with its used bit set and its dirty bit clear.
- R7: An access event (ev_valid=1) sets the used bit of frame ev_frame. If ev_write=1 as well, the event also sets that frame's dirty bit. With ev_write=0 the dirty bit is left unchanged.
- R8: A tick clears the used bit of every frame. If an access event or a victim restart hits a frame in the same cycle as a tick, that frame's used bit ends up set.
- R9: victim_dirty equals the victim's dirty bit as it stood in the cycle the victim was examined. An event in that same cycle does not change the reported value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Access event valid |
| ev_frame | input | IDX_W | Frame touched by the access event |
| ev_write | input | 1 | The access event is a write |
| tick | input | 1 | Periodic aging pulse that clears all used bits |
| fault_req | input | 1 | Request for a victim frame |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse marking a valid victim |
| victim | output | IDX_W | Index of the chosen frame, held until the next choice |
| victim_dirty | output | 1 | The chosen frame must be written back before it is reused |

## Verification
The bound assertions check, on every cycle, the local rules of the search:
- busy rises only after a request.
- done is a single-cycle pulse and never overlaps busy.
- The victim is the frame the hand pointed at in the previous cycle, and the hand now sits one position past it.
- A swept frame loses its used bit, and the restarted frame keeps its used bit set.
- A quiet tick leaves no used bit set.
- The reported dirty flag matches the dirty state the frame had when it was examined.

Some behaviours only the bench's behavioural model can show across longer scenarios:
- The choice of victim over many faults.
- The full sweep that falls back to first-in first-out order.
- Dirty state that builds up over many writes.
- The order in which a tick, an access event and a restart resolve when they meet on the same frame.

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int FRAMES = 8,
  localparam int IDX_W = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic [IDX_W-1:0] ev_frame,
  input  logic             ev_write,
  input  logic             tick,
  input  logic             fault_req,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] victim,
  output logic             victim_dirty
);

  logic [FRAMES-1:0] refd, modd, refd_nx, modd_nx;
  logic [IDX_W-1:0]  hand, hand_inc;
  logic              pick;

  // Stop on the frame under the hand if its used bit is clear.
  assign pick     = busy & ~refd[hand];
  assign hand_inc = (hand == IDX_W'(FRAMES - 1)) ? '0 : hand + 1'b1;

  // Per-frame update. Later assignments win: tick first, then the hand's
  // clear or restart, then the access event.
  always_comb begin
    for (int i = 0; i < FRAMES; i++) begin
      refd_nx[i] = refd[i];
      modd_nx[i] = modd[i];
      if (tick)
        refd_nx[i] = 1'b0;
      if (busy && hand == IDX_W'(i)) begin
        refd_nx[i] = pick;
        if (pick)
          modd_nx[i] = 1'b0;
      end
      if (ev_valid && ev_frame == IDX_W'(i)) begin
        refd_nx[i] = 1'b1;
        if (ev_write)
          modd_nx[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refd         <= '0;
      modd         <= '0;
      hand         <= '0;
      busy         <= 1'b0;
      done         <= 1'b0;
      victim       <= '0;
      victim_dirty <= 1'b0;
    end else begin
      refd <= refd_nx;
      modd <= modd_nx;
      done <= 1'b0;
      if (!busy) begin
        busy <= fault_req;
      end else begin
        hand <= hand_inc;
        if (pick) begin
          busy         <= 1'b0;
          done         <= 1'b1;
          victim       <= hand;
          victim_dirty <= modd[hand];
        end
      end
    end
  end

endmodule

// File: rtl/clock_victim_chk.sv
module clock_victim_chk #(
  parameter int FRAMES = 8,
  localparam int IDX_W = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_valid,
  input logic [IDX_W-1:0] ev_frame,
  input logic             tick,
  input logic             fault_req,
  input logic             busy,
  input logic             done,
  input logic [IDX_W-1:0] victim,
  input logic             victim_dirty,
  input logic [IDX_W-1:0] hand,
  input logic [FRAMES-1:0] refd,
  input logic [FRAMES-1:0] modd
);

  p_busy_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(fault_req));

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  p_victim_was_hand_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> victim == $past(hand));

  p_sweep_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && refd[hand] && !(ev_valid && ev_frame == hand) |=> !refd[$past(hand)]);

  p_hand_past_victim_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> hand == ((victim == IDX_W'(FRAMES - 1)) ? '0 : victim + 1'b1));

  p_restart_used_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> refd[victim]);

  p_tick_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !busy && !ev_valid |=> refd == '0);

  p_dirty_report_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> victim_dirty == $past(modd[hand]));

endmodule

bind clock_victim_sel clock_victim_chk #(.FRAMES(FRAMES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_frame(ev_frame),
  .tick(tick), .fault_req(fault_req), .busy(busy), .done(done),
  .victim(victim), .victim_dirty(victim_dirty), .hand(hand),
  .refd(refd), .modd(modd)
);

// File: tb/tb_clock_victim_sel.sv
module tb_clock_victim_sel;
  localparam int FRAMES = 8;
  localparam int IDX_W = $clog2(FRAMES);
  localparam time TCLK = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0, ev_write = 1'b0, tick = 1'b0, fault_req = 1'b0;
  logic [IDX_W-1:0] ev_frame = '0;
  logic busy, done, victim_dirty;
  logic [IDX_W-1:0] victim;

  clock_victim_sel #(.FRAMES(FRAMES)) dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_frame(ev_frame),
    .ev_write(ev_write), .tick(tick), .fault_req(fault_req), .busy(busy),
    .done(done), .victim(victim), .victim_dirty(victim_dirty)
  );

  always #(TCLK/2) clk = ~clk;

  // Behavioural reference model
  int m_ref[FRAMES];
  int m_mod[FRAMES];
  int m_hand, m_victim;
  bit m_busy, m_done, m_dirty;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_ref[i]) begin m_ref[i] = 0; m_mod[i] = 0; end
      m_hand = 0; m_busy = 0; m_done = 0; m_victim = 0; m_dirty = 0;
    end else begin
      int nref[FRAMES];
      int nmod[FRAMES];
      int h;
      bit chosen;
      h = m_hand;
      chosen = 0;
      foreach (nref[i]) begin nref[i] = m_ref[i]; nmod[i] = m_mod[i]; end
      if (tick) foreach (nref[i]) nref[i] = 0;
      m_done = 0;
      if (!m_busy) begin
        m_busy = fault_req;
      end else begin
        if (m_ref[h] == 0) begin
          chosen = 1;
          m_victim = h;
          m_dirty = (m_mod[h] != 0);
          nref[h] = 1;
          nmod[h] = 0;
        end else begin
          nref[h] = 0;
        end
        m_hand = (h + 1) % FRAMES;
        if (chosen) begin m_busy = 0; m_done = 1; end
      end
      if (ev_valid) begin
        nref[int'(ev_frame)] = 1;
        if (ev_write) nmod[int'(ev_frame)] = 1;
      end
      foreach (nref[i]) begin m_ref[i] = nref[i]; m_mod[i] = nmod[i]; end
    end
  end

  int vectors = 0;
  int errors = 0;
  string tag = "R1";
  bit finished = 0;

  task automatic compare();
    vectors++;
    if (busy !== m_busy || done !== m_done || victim !== IDX_W'(m_victim) ||
        victim_dirty !== m_dirty) begin
      errors++;
      $display("FAIL %s t=%0t busy/done/victim/dirty actual %0b/%0b/%0d/%0b expected %0b/%0b/%0d/%0b",
               tag, $time, busy, done, victim, victim_dirty,
               m_busy, m_done, m_victim, m_dirty);
    end
  endtask

  task automatic cyc(input bit fr, input bit ev, input int fn, input bit wr, input bit tk);
    @(negedge clk);
    compare();
    fault_req = fr; ev_valid = ev; ev_frame = IDX_W'(fn); ev_write = wr; tick = tk;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1"; idle(2);
    cyc(1, 0, 0, 0, 0); idle(4);                       // victim 0, clean

    tag = "R7";                                          // reads and writes
    cyc(0, 1, 1, 0, 0); cyc(0, 1, 2, 1, 0); cyc(0, 1, 3, 1, 0); idle(1);
    tag = "R4"; cyc(1, 0, 0, 0, 0); idle(6);            // sweeps 1,2,3 then picks 4

    tag = "R2"; cyc(1, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0); idle(4);

    tag = "R5";                                          // all used -> FIFO fallback
    for (int f = 0; f < FRAMES; f++) cyc(0, 1, f, 0, 0);
    cyc(1, 0, 0, 0, 0); idle(FRAMES + 4);

    tag = "R9";                                          // dirty victim after tick
    for (int f = 0; f < FRAMES; f++) cyc(0, 1, f, 1, 0);
    cyc(0, 0, 0, 0, 1);
    cyc(1, 0, 0, 0, 0); idle(4);
    cyc(1, 0, 0, 0, 0); cyc(0, 1, 3, 1, 0); idle(4);    // event during examination

    tag = "R8";                                          // tick and event together
    cyc(0, 1, 5, 0, 1); cyc(1, 0, 0, 0, 0); idle(FRAMES + 3);
    cyc(0, 0, 0, 0, 1); cyc(1, 0, 0, 0, 1); cyc(0, 0, 0, 0, 1); idle(3);

    tag = "R6"; cyc(1, 0, 0, 0, 0); idle(3); cyc(1, 0, 0, 0, 0); idle(FRAMES + 3);

    tag = "R3";                                          // mixed random traffic
    for (int n = 0; n < 3000; n++)
      cyc(($urandom % 6) == 0, ($urandom % 3) != 0, $urandom % FRAMES,
          ($urandom % 4) == 0, ($urandom % 23) == 0);
    idle(FRAMES + 4);

    tag = "R1"; rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    idle(2); cyc(1, 0, 0, 0, 0); idle(4);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    finish_run();
  end
endmodule